// File: doc/BRIEF.md
# Codec Bit Clock and Frame Sync Generator

This block derives the bit clock and the frame sync of a serial voice codec port from a fast system clock. Two chained programmable dividers do the work. A prescaler divides the system clock by (N+1) to make the bit clock. A frame counter divides the bit clock by (M+1) to set the sample rate. The frame sync pulse is either one bit clock wide (short frame) or as wide as one sample (long frame: 8 or 16 bit clocks).

Software controls the block with command words. A configuration word selects the sample width, master or slave mode and the frame sync style. Its arm flag makes the next accepted word a divider word. A divider word that breaks the range or ratio rules is dropped and raises a sticky error. A divider word that passes is held pending and takes effect at the next frame boundary, so no frame is ever cut short.

In master mode the block drives both pads. In slave mode the pads are released and the external clocks are passed to the monitor outputs. The bit clock comes from a clock-enable pulse and a registered output level, never from a derived clock net.

Top module: `codec_clkgen`

## Requirements
- R1: A divider word carries N in bits [4:0]. It is accepted only if N+1 lies in 4..32, that is N >= 3. Otherwise it is rejected.
- R2: With divider N in effect, the bit clock has a period of N+1 system clocks. It is high for floor((N+2)/2) of those cycles, starting at the cycle that follows a prescaler wrap.
- R3: A divider word carries M in bits [13:5]. It is accepted only if M+1 >= 16 while the width is 8-bit, or M+1 >= 32 while the width is 16-bit.
- R4: The frame period is (M+1) bit clocks. Frame sync rises together with a bit clock rising edge at frame start. In short-frame mode it stays high for one bit clock period.
- R5: In long-frame mode, frame sync stays high for 8 bit clocks when the width is 8-bit and for 16 bit clocks when the width is 16-bit.
- R6: After reset the block is in slave mode. In slave mode sclk_oe and fsync_oe are 0, sclk_o and fsync_o are 0, and bclk_mon and fsync_mon follow sclk_i and fsync_i. In master mode both enables are 1, and the outputs and monitors carry the generated clocks.
- R7: A rejected divider word sets rate_err, which stays set until reset. The dividers in effect do not change.
- R8: Command words use valid/ready and transfer when cmd_valid and cmd_ready are both high. A configuration word (block not armed) uses bit 0 for 16-bit width, bit 1 for master, bit 2 for long frame and bit 3 for arm. The next word accepted after an arm is a divider word, and it disarms the block. cmd_ready is low from the acceptance of a valid divider word until that word is applied; this is the only back-pressure.
- R9: An accepted divider word takes effect only at the bit clock rising edge that ends the current frame.
- R10: Out of reset the dividers hold the parameter values N_RST and M_RST (defaults 18 and 255: 2.048 MHz and 8 kHz from 38.912 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word can be accepted |
| cmd_data | input | 14 | Configuration or divider word |
| sclk_i | input | 1 | External bit clock (slave mode) |
| sclk_o | output | 1 | Generated bit clock to the pad |
| sclk_oe | output | 1 | Bit clock pad drive enable |
| fsync_i | input | 1 | External frame sync (slave mode) |
| fsync_o | output | 1 | Generated frame sync to the pad |
| fsync_oe | output | 1 | Frame sync pad drive enable |
| bclk_mon | output | 1 | Bit clock in use (generated or external) |
| fsync_mon | output | 1 | Frame sync in use (generated or external) |
| rate_err | output | 1 | Sticky: a divider word was rejected |

## Verification
The bench builds the block with N_RST=4 and M_RST=15 and keeps the default field widths. With these values a frame lasts 80 system clocks, so many frames and several rate changes fit into a short run. M_RST sits exactly at the 8-bit ratio minimum, so the smallest legal settings (N=3, M=15) can be loaded and the same M can be rejected after a switch to 16-bit width. An odd N+1 out of reset exercises the uneven high/low split of the bit clock. Loading N=31 and M=31 reaches the top of the prescaler range and the 16-bit ratio minimum.

// File: rtl/codec_clkgen_pkg.sv
`timescale 1ns/1ps
package codec_clkgen_pkg;
  localparam int N_W_DEF      = 5;
  localparam int M_W_DEF      = 9;
  localparam int PL_W         = 5;
  localparam int N_MIN        = 3;
  localparam int FRAME_MIN_8  = 16;
  localparam int FRAME_MIN_16 = 32;
  localparam int PULSE_8      = 8;
  localparam int PULSE_16     = 16;

  localparam int CFG_WIDE_BIT   = 0;
  localparam int CFG_MASTER_BIT = 1;
  localparam int CFG_LONG_BIT   = 2;
  localparam int CFG_ARM_BIT    = 3;

  typedef struct packed {
    logic long_fs;
    logic master;
    logic wide16;
  } clk_cfg_t;

  function automatic logic [PL_W-1:0] pulse_bits(clk_cfg_t c);
    if (!c.long_fs) return PL_W'(1);
    return c.wide16 ? PL_W'(PULSE_16) : PL_W'(PULSE_8);
  endfunction
endpackage

// File: rtl/codec_bit_div.sv
`timescale 1ns/1ps
module codec_bit_div #(
  parameter int N_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_cur,
  output logic           tick,
  output logic           sclk_q
);
  logic [N_W-1:0] cnt;
  logic [N_W-1:0] cnt_nxt;
  logic [N_W:0]   hi_len;

  assign tick    = (cnt == n_cur);
  assign cnt_nxt = tick ? '0 : cnt + N_W'(1);
  assign hi_len  = ({1'b0, n_cur} + (N_W+1)'(2)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt    <= cnt_nxt;
      sclk_q <= ({1'b0, cnt_nxt} < hi_len);
    end
  end

  // R2: each prescaler wrap starts a high phase of the bit clock
  assert_rise_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sclk_q);

  // R2: the count never passes the divider in effect
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= n_cur);
endmodule

// File: rtl/codec_frame_div.sv
`timescale 1ns/1ps
module codec_frame_div #(
  parameter int M_W  = 9,
  parameter int PL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [M_W-1:0]  m_cur,
  input  logic [PL_W-1:0] plen,
  output logic            frame_end,
  output logic            fsync_q
);
  logic [M_W-1:0] fcnt;
  logic [M_W-1:0] fcnt_nxt;

  assign frame_end = tick && (fcnt == m_cur);
  assign fcnt_nxt  = frame_end ? '0 : fcnt + M_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt    <= '0;
      fsync_q <= 1'b1;
    end else if (tick) begin
      fcnt    <= fcnt_nxt;
      fsync_q <= (fcnt_nxt < M_W'(plen));
    end
  end

  // R4: frame sync only moves on a bit clock edge
  assert_fsync_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync_q) |-> $past(tick));
endmodule

// File: rtl/codec_cmd_ctrl.sv
`timescale 1ns/1ps
module codec_cmd_ctrl import codec_clkgen_pkg::*; #(
  parameter int N_W   = N_W_DEF,
  parameter int M_W   = M_W_DEF,
  parameter int N_RST = 18,
  parameter int M_RST = 255,
  localparam int CMD_W = N_W + M_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             cmd_ready,
  input  logic             frame_end,
  output clk_cfg_t         cfg,
  output logic [N_W-1:0]   n_cur,
  output logic [M_W-1:0]   m_cur,
  output logic             rate_err
);
  logic           armed;
  logic           pending;
  logic [N_W-1:0] pend_n;
  logic [M_W-1:0] pend_m;
  logic [N_W-1:0] rate_n;
  logic [M_W-1:0] rate_m;
  logic [M_W:0]   need_bits;
  logic           rate_ok;
  logic           accept;

  assign cmd_ready = !pending;
  assign accept    = cmd_valid && cmd_ready;
  assign rate_n    = cmd_data[N_W-1:0];
  assign rate_m    = cmd_data[CMD_W-1:N_W];
  assign need_bits = cfg.wide16 ? (M_W+1)'(FRAME_MIN_16) : (M_W+1)'(FRAME_MIN_8);
  assign rate_ok   = (rate_n >= N_W'(N_MIN)) &&
                     (({1'b0, rate_m} + (M_W+1)'(1)) >= need_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      armed    <= 1'b0;
      pending  <= 1'b0;
      pend_n   <= '0;
      pend_m   <= '0;
      n_cur    <= N_W'(N_RST);
      m_cur    <= M_W'(M_RST);
      rate_err <= 1'b0;
    end else begin
      if (frame_end && pending) begin
        n_cur   <= pend_n;
        m_cur   <= pend_m;
        pending <= 1'b0;
      end
      if (accept) begin
        if (armed) begin
          armed <= 1'b0;
          if (rate_ok) begin
            pending <= 1'b1;
            pend_n  <= rate_n;
            pend_m  <= rate_m;
          end else begin
            rate_err <= 1'b1;
          end
        end else begin
          cfg.wide16  <= cmd_data[CFG_WIDE_BIT];
          cfg.master  <= cmd_data[CFG_MASTER_BIT];
          cfg.long_fs <= cmd_data[CFG_LONG_BIT];
          armed       <= cmd_data[CFG_ARM_BIT];
        end
      end
    end
  end

  // R1: the prescaler setting in effect is never below the minimum
  assert_n_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    n_cur >= N_W'(N_MIN));

  // R3: a word that goes pending satisfies the ratio for the current width
  assert_pend_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> (({1'b0, pend_m} + (M_W+1)'(1)) >= need_bits));

  // R7: the error flag never clears outside reset
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |=> rate_err);

  // R9: the dividers change only right after a frame boundary
  assert_div_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(n_cur) || !$stable(m_cur)) |-> $past(frame_end));
endmodule

// File: rtl/codec_clkgen.sv
`timescale 1ns/1ps
module codec_clkgen import codec_clkgen_pkg::*; #(
  parameter int N_W   = N_W_DEF,
  parameter int M_W   = M_W_DEF,
  parameter int N_RST = 18,
  parameter int M_RST = 255,
  localparam int CMD_W = N_W + M_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             fsync_i,
  output logic             fsync_o,
  output logic             fsync_oe,
  output logic             bclk_mon,
  output logic             fsync_mon,
  output logic             rate_err
);
  clk_cfg_t       cfg;
  logic [N_W-1:0] n_cur;
  logic [M_W-1:0] m_cur;
  logic           tick;
  logic           sclk_q;
  logic           frame_end;
  logic           fsync_q;

  codec_cmd_ctrl #(.N_W(N_W), .M_W(M_W), .N_RST(N_RST), .M_RST(M_RST)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .frame_end(frame_end), .cfg(cfg),
    .n_cur(n_cur), .m_cur(m_cur), .rate_err(rate_err)
  );

  codec_bit_div #(.N_W(N_W)) bit_i (
    .clk(clk), .rst_n(rst_n), .n_cur(n_cur), .tick(tick), .sclk_q(sclk_q)
  );

  codec_frame_div #(.M_W(M_W), .PL_W(PL_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .m_cur(m_cur),
    .plen(pulse_bits(cfg)), .frame_end(frame_end), .fsync_q(fsync_q)
  );

  assign sclk_oe   = cfg.master;
  assign fsync_oe  = cfg.master;
  assign sclk_o    = cfg.master & sclk_q;
  assign fsync_o   = cfg.master & fsync_q;
  assign bclk_mon  = cfg.master ? sclk_q  : sclk_i;
  assign fsync_mon = cfg.master ? fsync_q : fsync_i;

  // R4: a driven frame sync rises only together with the driven bit clock
  assert_frame_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fsync_o) && $past(sclk_oe)) |-> $rose(sclk_o));

  // R6: released pads carry no level
  assert_slave_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_oe |-> (!sclk_o && !fsync_o && !fsync_oe));
endmodule

// File: tb/codec_clkgen_tb_top.sv
`timescale 1ns/1ps
module codec_clkgen_tb_top;
  localparam int NR = 4;
  localparam int MR = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [13:0] cmd_data = '0;
  logic sclk_i = 1'b0;
  logic fsync_i = 1'b0;
  logic cmd_ready, sclk_o, sclk_oe, fsync_o, fsync_oe, bclk_mon, fsync_mon, rate_err;

  int compared = 0;
  int mismatched = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_clkgen #(.N_RST(NR), .M_RST(MR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .fsync_i(fsync_i), .fsync_o(fsync_o), .fsync_oe(fsync_oe),
    .bclk_mon(bclk_mon), .fsync_mon(fsync_mon), .rate_err(rate_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: plain integers, updated once per clock
  int rm_cnt = 0, rm_fc = 0, rm_n = NR, rm_m = MR;
  int rm_pn = 0, rm_pm = 0;
  bit rm_pend = 0, rm_arm = 0, rm_err = 0;
  bit rm_w16 = 0, rm_mst = 0, rm_long = 0;
  bit rm_sc = 1, rm_fs = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      rm_cnt = 0; rm_fc = 0; rm_n = NR; rm_m = MR; rm_pend = 0; rm_arm = 0;
      rm_err = 0; rm_w16 = 0; rm_mst = 0; rm_long = 0; rm_sc = 1; rm_fs = 1;
    end else begin
      bit tk, bnd, rdy;
      int plen, nn, mm, need;
      tk = (rm_cnt == rm_n);
      bnd = tk && (rm_fc == rm_m);
      rdy = !rm_pend;
      plen = rm_long ? (rm_w16 ? 16 : 8) : 1;
      if (tk) begin
        rm_cnt = 0;
        rm_fc = bnd ? 0 : rm_fc + 1;
        rm_fs = (rm_fc < plen);
      end else begin
        rm_cnt = rm_cnt + 1;
      end
      if (bnd && rm_pend) begin
        rm_n = rm_pn; rm_m = rm_pm; rm_pend = 0;
      end
      rm_sc = (rm_cnt < (rm_n + 2) / 2);
      if (cmd_valid && rdy) begin
        if (rm_arm) begin
          rm_arm = 0;
          nn = int'(cmd_data[4:0]);
          mm = int'(cmd_data[13:5]);
          need = rm_w16 ? 32 : 16;
          if (nn >= 3 && mm + 1 >= need) begin
            rm_pend = 1; rm_pn = nn; rm_pm = mm;
          end else rm_err = 1;
        end else begin
          rm_w16 = cmd_data[0]; rm_mst = cmd_data[1];
          rm_long = cmd_data[2]; rm_arm = cmd_data[3];
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      chk("R2 sclk_o", sclk_o, rm_mst ? rm_sc : 0);
      chk("R4 R5 fsync_o", fsync_o, rm_mst ? rm_fs : 0);
      chk("R6 sclk_oe", sclk_oe, rm_mst);
      chk("R6 fsync_oe", fsync_oe, rm_mst);
      chk("R6 bclk_mon", bclk_mon, rm_mst ? rm_sc : sclk_i);
      chk("R6 fsync_mon", fsync_mon, rm_mst ? rm_fs : fsync_i);
      chk("R8 cmd_ready", cmd_ready, !rm_pend);
      chk("R7 rate_err", rate_err, rm_err);
    end
  end

  function automatic logic [13:0] cfg_w(bit w16, bit mst, bit lng, bit arm);
    return {10'b0, arm, lng, mst, w16};
  endfunction

  function automatic logic [13:0] rate_w(int n, int m);
    return {m[8:0], n[4:0]};
  endfunction

  task automatic send(input logic [13:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = w;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic bit pick(input int sel);
    return (sel == 0) ? sclk_o : fsync_o;
  endfunction

  task automatic wait_rise(input int sel);
    bit prev, cur;
    @(negedge clk); #1;
    prev = pick(sel);
    forever begin
      @(negedge clk); #1;
      cur = pick(sel);
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic rise_gap(input int sel, output int g);
    bit prev, cur;
    wait_rise(sel);
    g = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk); #1;
      g++;
      cur = pick(sel);
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic high_len(input int sel, output int h);
    wait_rise(sel);
    h = 1;
    forever begin
      @(negedge clk); #1;
      if (!pick(sel)) break;
      h++;
    end
  endtask

  task automatic wait_applied();
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk); #1;
    chk("R6 reset slave oe", sclk_oe, 0);
    chk("R7 reset err", rate_err, 0);
    chk("R8 reset ready", cmd_ready, 1);

    // master, 8-bit, short frame; reset dividers
    send(cfg_w(0, 1, 0, 0));
    rise_gap(0, v); chk("R10 reset bit period", v, NR + 1);
    rise_gap(1, v); chk("R4 reset frame period", v, (NR + 1) * (MR + 1));
    high_len(1, v); chk("R4 short pulse", v, NR + 1);

    // smallest legal settings for 8-bit
    send(cfg_w(0, 1, 0, 1));
    send(rate_w(3, 15));
    #1; chk("R9 pending holds ready low", cmd_ready, 0);
    wait_applied();
    chk("R3 boundary accepted", rate_err, 0);
    rise_gap(0, v); chk("R2 bit period N=3", v, 4);
    rise_gap(1, v); chk("R4 frame period", v, 64);

    send(cfg_w(0, 1, 1, 0));
    high_len(1, v); chk("R5 long pulse 8-bit", v, 8 * 4);

    // 16-bit width makes M=15 illegal
    send(cfg_w(1, 1, 1, 1));
    send(rate_w(3, 15));
    #1; chk("R3 ratio reject err", rate_err, 1);
    chk("R7 reject leaves no pending", cmd_ready, 1);

    // prescaler below range
    send(cfg_w(1, 1, 1, 1));
    send(rate_w(2, 40));
    #1; chk("R1 range reject ready", cmd_ready, 1);
    rise_gap(0, v); chk("R1 period unchanged", v, 4);

    // top of prescaler range, 16-bit minimum ratio
    send(cfg_w(1, 1, 1, 1));
    send(rate_w(31, 31));
    wait_applied();
    rise_gap(0, v); chk("R2 bit period N=31", v, 32);
    rise_gap(1, v); chk("R4 frame period 16-bit", v, 32 * 32);
    high_len(1, v); chk("R5 long pulse 16-bit", v, 16 * 32);
    send(cfg_w(1, 1, 0, 0));
    high_len(1, v); chk("R4 short pulse 16-bit", v, 32);

    // slave: pads released, external clocks passed through
    send(cfg_w(0, 0, 0, 0));
    #1; chk("R6 slave oe", sclk_oe, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sclk_i = ~sclk_i;
      if (i == 2) fsync_i = 1'b1;
      if (i == 4) fsync_i = 1'b0;
      #1;
      chk("R6 bclk passthrough", bclk_mon, sclk_i);
      chk("R6 fsync passthrough", fsync_mon, fsync_i);
      chk("R6 sclk_o quiet", sclk_o, 0);
    end
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule